// File: doc/BRIEF.md
# Serial Shift Unit with Address-Match Wake-Up

An 8-bit shift register turns a byte into a serial stream and collects a serial stream into a byte, both timed by an external serial clock. That clock is first synchronized into the system clock domain. The unit has two pin modes. In the first, data goes out on a dedicated output and comes in on a dedicated input. In the second, it shares one open-drain data line with other devices.

In the shared-line mode, a byte received with wake-up selected is treated as an address. It is compared with a programmable slave address. The result of that comparison does three things:
- it sets or clears a coincidence flag;
- a mismatch clears a bus-release flag;
- a mismatch holds back the transfer interrupt, so a sleeping device is woken only when it is addressed.

An option bit moves the interrupt to the bus-release strobe instead, and this option overrides wake-up.

Top module: `ser_addr_shifter`

## Requirements
- R1: A write to the shift register (`wr_shift`) always loads `wr_data`. A transfer starts only if `en` is 1 at that write. With `en` at 0, `active` stays 0 and serial clocks change nothing.
- R2: Bits move MSB first. Received bits are sampled on serial-clock rising edges. The output bit changes on falling edges. The first output bit is valid as soon as the register is loaded. The transfer ends after the 8th rising edge.
- R3: When neither wake-up nor the release option applies, `irq` is high for exactly one system clock at the end of every transfer.
- R4: When `bus_mode`=1, the byte is received from and sent on the shared line. `sda_oe` is 1 only while a transfer is active and the current output bit is 0. The line reads back as the wired-AND of all drivers.
- R5: A receiver in `bus_mode` that is loaded with 0xFF never asserts `sda_oe` during the transfer.
- R6: With `bus_mode`=1 and `wake_en`=1, each completed byte is compared with the slave address (`wr_sva` loads it from `wr_data`). `coin` becomes 1 when they are equal and 0 otherwise. `coin` changes at no other time.
- R7: With `addr_mask`=1, only bits 7..1 are compared and bit 0 is ignored.
- R8: An address byte that does not match clears `rel_flag`. A `rel_strobe` pulse sets it. If both happen in the same cycle, the set wins.
- R9: With wake-up applying, the completion interrupt fires only when the address matches.
- R10: With `irq_at_release`=1, `irq` follows each `rel_strobe` one cycle later. No completion interrupt fires, even with `wake_en`=1.
- R11: In `bus_mode` with `busy_en`=1, a completed transfer sets `busy`. A shift-register write in `bus_mode` clears it.
- R12: A write that lands in the same cycle as a transfer's final rising edge wins. It reloads the register and restarts the count, and that cycle produces no completion interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_shift | input | 1 | Write strobe for the shift register |
| wr_sva | input | 1 | Write strobe for the slave address |
| wr_data | input | 8 | Write data |
| en | input | 1 | Interface enable |
| bus_mode | input | 1 | 1 = shared open-drain line |
| wake_en | input | 1 | Address reception with wake-up |
| addr_mask | input | 1 | Ignore the address LSB |
| irq_at_release | input | 1 | Interrupt on bus release |
| busy_en | input | 1 | Enable busy setting |
| sclk | input | 1 | Serial clock (asynchronous) |
| sin | input | 1 | Serial input, separate-pin mode |
| sda_in | input | 1 | Shared line level |
| rel_strobe | input | 1 | Bus-release event pulse |
| shift_q | output | 8 | Shift register contents |
| sout | output | 1 | Serial output bit |
| sda_oe | output | 1 | Pull shared line low |
| coin | output | 1 | Address coincidence flag |
| rel_flag | output | 1 | Bus-release flag |
| busy | output | 1 | Busy state |
| irq | output | 1 | Interrupt pulse |
| active | output | 1 | Transfer in progress |

## Verification
Two pairs of events can fall in the same system cycle. The first pair is a CPU write to the shift register and the detected final rising edge of a transfer. The second is a bus-release strobe and the completion of a non-matching address byte. The bench times each collision by raising `sclk` and counting the two synchronizer stages, so that the write or the strobe is sampled on exactly the edge where the rising edge acts. It then judges the result at the ports:
- after the write collision, there is no interrupt, a new transfer is running, and the new data is loaded;
- after the strobe collision, `rel_flag` is set.

// File: rtl/ser_addr_shifter.sv
module ser_addr_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_shift,
  input  logic         wr_sva,
  input  logic [W-1:0] wr_data,
  input  logic         en,
  input  logic         bus_mode,
  input  logic         wake_en,
  input  logic         addr_mask,
  input  logic         irq_at_release,
  input  logic         busy_en,
  input  logic         sclk,
  input  logic         sin,
  input  logic         sda_in,
  input  logic         rel_strobe,
  output logic [W-1:0] shift_q,
  output logic         sout,
  output logic         sda_oe,
  output logic         coin,
  output logic         rel_flag,
  output logic         busy,
  output logic         irq,
  output logic         active
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0]    sk;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sva;
  logic          out_q;

  wire rise      = sk[1] & ~sk[2];
  wire fall      = ~sk[1] & sk[2];
  wire din       = bus_mode ? sda_in : sin;
  wire [W-1:0] nxt = {shift_q[W-2:0], din};
  wire done      = active & rise & (cnt == LAST) & ~wr_shift;
  wire addr_byte = bus_mode & wake_en;
  wire match     = addr_mask ? (nxt[W-1:1] == sva[W-1:1]) : (nxt == sva);

  assign sout   = out_q;
  assign sda_oe = bus_mode & active & ~out_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sk <= '0;
    else        sk <= {sk[1:0], sclk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      out_q   <= 1'b1;
      cnt     <= '0;
      active  <= 1'b0;
    end else if (wr_shift) begin
      shift_q <= wr_data;
      out_q   <= wr_data[W-1];
      cnt     <= '0;
      active  <= en;
    end else if (active) begin
      if (rise) begin
        shift_q <= nxt;
        cnt     <= cnt + 1'b1;
        if (cnt == LAST) active <= 1'b0;
      end else if (fall) begin
        out_q <= shift_q[W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sva      <= '0;
      coin     <= 1'b0;
      rel_flag <= 1'b0;
      busy     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_sva) sva <= wr_data;
      if (done && addr_byte) coin <= match;
      if (rel_strobe) rel_flag <= 1'b1;
      else if (done && addr_byte && !match) rel_flag <= 1'b0;
      if (wr_shift && bus_mode) busy <= 1'b0;
      else if (done && bus_mode && busy_en) busy <= 1'b1;
      irq <= irq_at_release ? rel_strobe : (done & (~addr_byte | match));
    end
  end

  a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shift && !en) |=> !active);
  a_r4_oe_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (active && !sout && bus_mode));
  a_r6_coin_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && rise) |=> $stable(coin));
  a_r10_irq_from_release: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(irq_at_release)) |-> $past(rel_strobe));
  a_r11_busy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shift && bus_mode) |=> !busy);
endmodule

// File: tb/ser_addr_shifter_tb.sv
module ser_addr_shifter_tb;
  logic clk = 0, rst_n = 0;
  logic wr_shift = 0, wr_sva = 0;
  logic [7:0] wr_data = 0;
  logic en = 0, bus_mode = 0, wake_en = 0, addr_mask = 0, irq_at_release = 0, busy_en = 0;
  logic sclk = 0, sin = 0, ext = 1, rel_strobe = 0;
  logic [7:0] shift_q;
  logic sout, sda_oe, coin, rel_flag, busy, irq, active;
  wire sda_in = ext & ~sda_oe;

  int checks = 0, fails = 0, irq_cnt = 0, oe_cnt = 0, cyc = 0;

  always #5 clk = ~clk;

  ser_addr_shifter u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel_sva, input [7:0] v);
    @(negedge clk);
    wr_data = v;
    if (sel_sva) wr_sva = 1; else wr_shift = 1;
    @(negedge clk);
    wr_sva = 0; wr_shift = 0;
  endtask

  task automatic bit_clk(input logic b, output logic o);
    sin = b; ext = b;
    idle(4);
    o = bus_mode ? sda_in : sout;
    sclk = 1; idle(4);
    sclk = 0; idle(4);
  endtask

  task automatic xfer(input [7:0] rx, output [7:0] tx);
    for (int i = 7; i >= 0; i--) bit_clk(rx[i], tx[i]);
    ext = 1;
    idle(4);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] tx;
    logic [7:0] sva;
    int i0;
    idle(3); rst_n = 1; idle(2);
    chk("reset active", active, 0); chk("reset irq", irq, 0);
    chk("reset coin", coin, 0); chk("reset rel", rel_flag, 0);
    chk("reset busy", busy, 0); chk("reset oe", sda_oe, 0);

    // R1 disabled write
    wr(0, 8'h3C);
    chk("R1 loaded", shift_q, 8'h3C); chk("R1 idle", active, 0);
    i0 = irq_cnt; xfer(8'hFF, tx);
    chk("R1 unchanged", shift_q, 8'h3C); chk("R1 no irq", irq_cnt - i0, 0);

    // R2 R3 separate pins sweep
    en = 1;
    for (int v = 0; v < 256; v += 17) begin
      wr(0, 8'(v)); chk("R1 started", active, 1);
      i0 = irq_cnt;
      xfer(8'(255 - v), tx);
      chk("R2 tx", tx, v); chk("R2 rx", shift_q, 255 - v);
      chk("R2 done", active, 0); chk("R3 one irq", irq_cnt - i0, 1);
    end

    // R4 shared line transmit, R11 busy
    bus_mode = 1; busy_en = 1;
    for (int v = 1; v < 256; v += 51) begin
      wr(0, 8'(v)); chk("R11 busy cleared", busy, 0);
      xfer(8'hFF, tx);
      chk("R4 line", tx, v); chk("R4 readback", shift_q, v);
      chk("R11 busy set", busy, 1); chk("R4 oe off", sda_oe, 0);
    end
    // R5 receive with 0xFF
    i0 = oe_cnt; wr(0, 8'hFF); xfer(8'h5A, tx);
    chk("R5 rx", shift_q, 8'h5A); chk("R5 no oe", oe_cnt - i0, 0);
    busy_en = 0;

    // R6 R7 R8 R9 address sweep
    wake_en = 1; sva = 8'h6A; wr(1, sva);
    for (int m = 0; m < 2; m++) begin
      addr_mask = m[0];
      for (int a = 0; a < 256; a++) begin
        logic exp_m;
        exp_m = m[0] ? (a[7:1] == sva[7:1]) : (a[7:0] == sva);
        @(negedge clk); rel_strobe = 1; @(negedge clk); rel_strobe = 0;
        idle(2);
        i0 = irq_cnt;
        wr(0, 8'hFF); xfer(8'(a), tx);
        chk(m[0] ? "R7 coin" : "R6 coin", coin, exp_m);
        chk("R8 rel", rel_flag, exp_m);
        chk("R9 irq", irq_cnt - i0, exp_m);
      end
    end
    addr_mask = 0;

    // R8 collision: release strobe with non-match completion
    wr(0, 8'hFF);
    for (int i = 7; i >= 1; i--) bit_clk(1'b0, tx[i]);
    sin = 0; ext = 0; idle(4);
    sclk = 1; @(posedge clk); @(posedge clk);
    @(negedge clk); rel_strobe = 1; @(negedge clk); rel_strobe = 0;
    idle(3); sclk = 0; ext = 1; idle(6);
    chk("R8 set wins", rel_flag, 1); chk("R6 nomatch coin", coin, 0);

    // R10 irq at release
    irq_at_release = 1;
    i0 = irq_cnt; wr(0, 8'hFF); xfer(sva, tx);
    chk("R10 no completion irq", irq_cnt - i0, 0); chk("R10 coin", coin, 1);
    i0 = irq_cnt;
    @(negedge clk); rel_strobe = 1; @(negedge clk); rel_strobe = 0;
    chk("R10 irq high", irq, 1); idle(1); chk("R10 irq low", irq, 0);
    chk("R10 count", irq_cnt - i0, 1);
    irq_at_release = 0; wake_en = 0; bus_mode = 0;

    // R12 write collides with final rising edge
    wr(0, 8'h81);
    for (int i = 7; i >= 1; i--) bit_clk(1'b1, tx[i]);
    i0 = irq_cnt;
    sclk = 1; @(posedge clk); @(posedge clk);
    @(negedge clk); wr_data = 8'hC3; wr_shift = 1; @(negedge clk); wr_shift = 0;
    idle(3); sclk = 0; idle(6);
    chk("R12 no irq", irq_cnt - i0, 0); chk("R12 restarted", active, 1);
    chk("R12 data", shift_q, 8'hC3);
    xfer(8'h00, tx);
    chk("R12 tx", tx, 8'hC3); chk("R12 irq after", irq_cnt - i0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule